// File: doc/BRIEF.md
# Packed-Code Adaptive Differential Voice Sample Expander

This block turns a stream of bytes, each carrying two 4-bit adaptive differential codes, back into 16-bit signed voice samples. A byte is taken on an input valid/ready handshake. The block then emits two samples on an output valid/ready handshake: the upper nibble's sample first, then the lower nibble's sample.

For every code the block reads a step size from an internal 89-entry table at the current table index. Bits 2, 1 and 0 of the code select whether the step, half the step or a quarter of the step is added to a difference magnitude. Bit 3 selects the sign. The signed difference is added to the previous sample, and the sum is saturated to the 16-bit range. The table index then moves by an amount that depends on the code magnitude and is clamped. Each sample is the prediction for the next code, so an encoder that follows the same update rules tracks the decoder exactly.

Top module: `adpcm_byte_expander`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and both the prediction and the step index are 0. A first code of 4 therefore yields the sample 7.
- R2: A byte's upper nibble (bits 7..4) is decoded and presented before its lower nibble (bits 3..0).
- R3: The difference magnitude is the sum of S if code bit 2 is set, S>>1 if bit 1 is set, and S>>2 if bit 0 is set, where S is the table step. No other term is added. A code magnitude of 0 leaves the sample unchanged.
- R4: With code bit 3 equal to 1 the new sample is the previous sample minus the magnitude. With bit 3 equal to 0 it is the previous sample plus the magnitude.
- R5: The sample saturates at 32767 and at -32768.
- R6: The index changes by -1 for code magnitudes 0..3, and by +2, +4, +6 and +8 for magnitudes 4, 5, 6 and 7. The result is clamped to 0..88.
- R7: The step used for a code is read at the index held before that code's update. The steps run from 7 at index 0 to 32767 at index 88.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_sample` and `out_valid` hold.
- R9: `in_ready` is 0 while the upper-nibble sample is waiting. It is 1 when the block is empty, or when the lower-nibble sample is taken in the same cycle.
- R10: Over any byte sequence the samples equal those of an independent model of R3 to R7, started from the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Code byte offered |
| in_ready | output | 1 | Code byte can be taken |
| in_byte | input | 8 | Two codes, upper nibble decoded first |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Sample taken |
| out_sample | output | 16 | Decoded signed sample |

## Verification
The bench aims at the following corner cases:

- **Index floor.** It drives zero codes straight after reset. A design that lets the index go below zero would then read a step outside the table and give a first sample other than 7.
- **Step timing.** It checks small explicit sequences that tell the pre-update step apart from the post-update step. A design that reads the step after the update gives 9 instead of 7.
- **Saturation.** It drives runs of maximum-magnitude codes in both directions. A design that wraps instead of saturating would jump from near 32767 to a large negative value.
- **Handshake.** It checks sample stability under back-pressure, and it checks that a new byte is taken in the same cycle the second sample leaves. A design that accepts a byte too early would lose the pending lower nibble.

// File: rtl/adpcm_dec_pkg.sv
// Shared constants, types and table helpers for the packed-code expander.
// Assumes 16-bit samples and the fixed 89-entry step table.
package adpcm_dec_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int CODE_W      = 4;
    localparam int STEP_W      = 16;
    localparam int STEP_COUNT  = 89;
    localparam int IDX_W       = $clog2(STEP_COUNT);
    localparam int IDX_MAX     = STEP_COUNT - 1;
    localparam int ADJ_W       = 5;

    typedef enum logic [1:0] {
        SEQ_EMPTY = 2'd0,
        SEQ_HIGH  = 2'd1,
        SEQ_LOW   = 2'd2
    } seq_state_e;

    // Step sizes for indices 0..43.
    function automatic logic [STEP_W-1:0] step_lower(input logic [IDX_W-1:0] i);
        logic [STEP_W-1:0] v;
        case (i)
            7'd0:  v = 16'd7;     7'd1:  v = 16'd8;     7'd2:  v = 16'd9;
            7'd3:  v = 16'd10;    7'd4:  v = 16'd11;    7'd5:  v = 16'd12;
            7'd6:  v = 16'd13;    7'd7:  v = 16'd14;    7'd8:  v = 16'd16;
            7'd9:  v = 16'd17;    7'd10: v = 16'd19;    7'd11: v = 16'd21;
            7'd12: v = 16'd23;    7'd13: v = 16'd25;    7'd14: v = 16'd28;
            7'd15: v = 16'd31;    7'd16: v = 16'd34;    7'd17: v = 16'd37;
            7'd18: v = 16'd41;    7'd19: v = 16'd45;    7'd20: v = 16'd50;
            7'd21: v = 16'd55;    7'd22: v = 16'd60;    7'd23: v = 16'd66;
            7'd24: v = 16'd73;    7'd25: v = 16'd80;    7'd26: v = 16'd88;
            7'd27: v = 16'd97;    7'd28: v = 16'd107;   7'd29: v = 16'd118;
            7'd30: v = 16'd130;   7'd31: v = 16'd143;   7'd32: v = 16'd157;
            7'd33: v = 16'd173;   7'd34: v = 16'd190;   7'd35: v = 16'd209;
            7'd36: v = 16'd230;   7'd37: v = 16'd253;   7'd38: v = 16'd279;
            7'd39: v = 16'd307;   7'd40: v = 16'd337;   7'd41: v = 16'd371;
            7'd42: v = 16'd408;   7'd43: v = 16'd449;
            default: v = 16'd0;
        endcase
        return v;
    endfunction

    // Step sizes for indices 44..88.
    function automatic logic [STEP_W-1:0] step_upper(input logic [IDX_W-1:0] i);
        logic [STEP_W-1:0] v;
        case (i)
            7'd44: v = 16'd494;   7'd45: v = 16'd544;   7'd46: v = 16'd598;
            7'd47: v = 16'd658;   7'd48: v = 16'd724;   7'd49: v = 16'd796;
            7'd50: v = 16'd876;   7'd51: v = 16'd963;   7'd52: v = 16'd1060;
            7'd53: v = 16'd1166;  7'd54: v = 16'd1282;  7'd55: v = 16'd1411;
            7'd56: v = 16'd1552;  7'd57: v = 16'd1707;  7'd58: v = 16'd1878;
            7'd59: v = 16'd2066;  7'd60: v = 16'd2272;  7'd61: v = 16'd2499;
            7'd62: v = 16'd2749;  7'd63: v = 16'd3024;  7'd64: v = 16'd3327;
            7'd65: v = 16'd3660;  7'd66: v = 16'd4026;  7'd67: v = 16'd4428;
            7'd68: v = 16'd4871;  7'd69: v = 16'd5358;  7'd70: v = 16'd5894;
            7'd71: v = 16'd6484;  7'd72: v = 16'd7132;  7'd73: v = 16'd7845;
            7'd74: v = 16'd8630;  7'd75: v = 16'd9493;  7'd76: v = 16'd10442;
            7'd77: v = 16'd11487; 7'd78: v = 16'd12635; 7'd79: v = 16'd13899;
            7'd80: v = 16'd15289; 7'd81: v = 16'd16818; 7'd82: v = 16'd18500;
            7'd83: v = 16'd20350; 7'd84: v = 16'd22385; 7'd85: v = 16'd24623;
            7'd86: v = 16'd27086; 7'd87: v = 16'd29794; 7'd88: v = 16'd32767;
            default: v = 16'd32767;
        endcase
        return v;
    endfunction

    // Index movement: -1 for small magnitudes, then 2, 4, 6, 8.
    function automatic logic signed [ADJ_W-1:0] index_move(input logic [CODE_W-2:0] mag);
        logic signed [ADJ_W-1:0] v;
        if (mag[CODE_W-2]) v = ADJ_W'({1'b0, mag[CODE_W-3:0]} + 3'd1) <<< 1;
        else               v = -ADJ_W'(1);
        return v;
    endfunction

endpackage

// File: rtl/adpcm_step_rom.sv
// Step size look-up: maps a table index onto its quantiser step.
// Assumes the index never exceeds the last table entry; larger values
// return the top step.
module adpcm_step_rom
    import adpcm_dec_pkg::*;
#(
    parameter int SPLIT_AT = 44
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [STEP_W-1:0] step
);

    localparam logic [IDX_W-1:0] SPLIT_IDX = IDX_W'(SPLIT_AT);

    // Pick the half of the table that holds the requested entry.
    always_comb begin
        if (idx < SPLIT_IDX) step = step_lower(idx);
        else                 step = step_upper(idx);
    end

endmodule

// File: rtl/adpcm_code_update.sv
// Combinational update for one 4-bit code: rebuilds the signed difference
// from the step and its halves, saturates the new sample and moves the
// step index with clamping. Assumes the step is at most 2**(SAMPLE_W-1)-1.
module adpcm_code_update
    import adpcm_dec_pkg::*;
#(
    parameter int SMP_W  = SAMPLE_W,
    parameter int IX_W   = IDX_W,
    parameter int IX_MAX = IDX_MAX,
    parameter int ST_W   = STEP_W
) (
    input  logic signed [SMP_W-1:0] pred_in,
    input  logic [IX_W-1:0]         idx_in,
    input  logic [ST_W-1:0]         step,
    input  logic [CODE_W-1:0]       code,
    output logic signed [SMP_W-1:0] pred_out,
    output logic [IX_W-1:0]         idx_out
);

    localparam int WIDE  = SMP_W + 3;
    localparam int IWIDE = IX_W + 2;
    localparam logic signed [WIDE-1:0]  POS_LIM = WIDE'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [WIDE-1:0]  NEG_LIM = -POS_LIM - WIDE'(1);
    localparam logic signed [IWIDE-1:0] IDX_TOP = IWIDE'(IX_MAX);

    logic [WIDE-1:0]         magnitude;
    logic signed [WIDE-1:0]  pred_wide;
    logic signed [WIDE-1:0]  sum_wide;
    logic signed [ADJ_W-1:0] move;
    logic signed [IWIDE-1:0] idx_sum;

    // Difference magnitude from the three magnitude bits of the code.
    always_comb begin
        magnitude = '0;
        if (code[2]) magnitude = magnitude + WIDE'(step);
        if (code[1]) magnitude = magnitude + WIDE'(step >> 1);
        if (code[0]) magnitude = magnitude + WIDE'(step >> 2);
    end

    // Signed accumulation onto the previous sample, then saturation.
    always_comb begin
        pred_wide = {{(WIDE - SMP_W){pred_in[SMP_W-1]}}, pred_in};
        if (code[CODE_W-1]) sum_wide = pred_wide - $signed(magnitude);
        else                sum_wide = pred_wide + $signed(magnitude);
        if (sum_wide > POS_LIM)      pred_out = POS_LIM[SMP_W-1:0];
        else if (sum_wide < NEG_LIM) pred_out = NEG_LIM[SMP_W-1:0];
        else                         pred_out = sum_wide[SMP_W-1:0];
    end

    // Index movement from the code magnitude, clamped to the table.
    always_comb begin
        move    = index_move(code[CODE_W-2:0]);
        idx_sum = $signed({2'b00, idx_in}) + {{(IWIDE - ADJ_W){move[ADJ_W-1]}}, move};
        if (idx_sum < 0)            idx_out = '0;
        else if (idx_sum > IDX_TOP) idx_out = IDX_TOP[IX_W-1:0];
        else                        idx_out = idx_sum[IX_W-1:0];
    end

endmodule

// File: rtl/adpcm_nibble_seq.sv
// Byte-to-nibble sequencer: takes one byte, issues its upper code, holds
// the lower code until the first sample leaves, then issues the lower code.
// A new byte is taken only when empty, or when the lower-code sample is
// taken in the same cycle.
module adpcm_nibble_seq
    import adpcm_dec_pkg::*;
#(
    parameter int BYTE_W = 2 * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              update_en,
    output logic [CODE_W-1:0] code,
    output seq_state_e        state_o
);

    seq_state_e        state_q;
    logic [CODE_W-1:0] low_hold_q;
    logic              accept;
    logic              advance;

    // Handshake decode for both edges of the block.
    always_comb begin
        in_ready  = (state_q == SEQ_EMPTY) || ((state_q == SEQ_LOW) && out_ready);
        accept    = in_valid && in_ready;
        advance   = (state_q == SEQ_HIGH) && out_ready;
        update_en = accept || advance;
        out_valid = (state_q != SEQ_EMPTY);
        code      = accept ? in_byte[BYTE_W-1:CODE_W] : low_hold_q;
        state_o   = state_q;
    end

    // Sequencer state and held lower code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_EMPTY;
            low_hold_q <= '0;
        end else if (accept) begin
            state_q    <= SEQ_HIGH;
            low_hold_q <= in_byte[CODE_W-1:0];
        end else if (advance) begin
            state_q    <= SEQ_LOW;
        end else if ((state_q == SEQ_LOW) && out_ready) begin
            state_q    <= SEQ_EMPTY;
        end
    end

endmodule

// File: rtl/adpcm_byte_expander.sv
// Top: expands packed 4-bit adaptive differential codes into 16-bit samples.
// Holds the prediction (also the presented sample) and the step index.
// Assumes out_sample is sampled only while out_valid is high.
module adpcm_byte_expander
    import adpcm_dec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [2*CODE_W-1:0]        in_byte,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [SAMPLE_W-1:0] out_sample
);

    logic signed [SAMPLE_W-1:0] pred_q;
    logic signed [SAMPLE_W-1:0] pred_next;
    logic [IDX_W-1:0]           idx_q;
    logic [IDX_W-1:0]           idx_next;
    logic [STEP_W-1:0]          step;
    logic [CODE_W-1:0]          code;
    logic                       update_en;
    seq_state_e                 seq_state;

    adpcm_nibble_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .update_en (update_en),
        .code      (code),
        .state_o   (seq_state)
    );

    adpcm_step_rom u_rom (
        .idx  (idx_q),
        .step (step)
    );

    adpcm_code_update u_upd (
        .pred_in  (pred_q),
        .idx_in   (idx_q),
        .step     (step),
        .code     (code),
        .pred_out (pred_next),
        .idx_out  (idx_next)
    );

    // Prediction and index registers, updated once per issued code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            idx_q  <= '0;
        end else if (update_en) begin
            pred_q <= pred_next;
            idx_q  <= idx_next;
        end
    end

    // The presented sample is the current prediction.
    always_comb out_sample = pred_q;

endmodule

// File: rtl/adpcm_dec_checker.sv
// Property checker for the expander, attached by bind.
module adpcm_dec_checker
    import adpcm_dec_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [2*CODE_W-1:0]        in_byte,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic signed [SAMPLE_W-1:0] out_sample,
    input logic [IDX_W-1:0]           step_idx,
    input seq_state_e                 seq_state
);

    logic take;
    always_comb take = in_valid && in_ready;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_idx <= IDX_W'(IDX_MAX)); // R6

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sample)); // R8

    AST_NO_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == SEQ_HIGH |-> !in_ready); // R9

    AST_ZERO_MAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_byte[6:4] == 3'd0 |=> out_sample == $past(out_sample)); // R3

    AST_IDX_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        take && !in_byte[6] |=>
        step_idx == (($past(step_idx) == '0) ? '0 : $past(step_idx) - IDX_W'(1))); // R6

    AST_POSITIVE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        take && !in_byte[7] |=> out_sample >= $past(out_sample)); // R4

endmodule

bind adpcm_byte_expander adpcm_dec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .step_idx   (idx_q),
    .seq_state  (seq_state)
);

// File: tb/adpcm_byte_expander_tb.sv
module adpcm_byte_expander_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_byte = 8'h00;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic signed [15:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int ref_pred = 0;
    int ref_idx  = 0;

    always #4 clk = ~clk;

    adpcm_byte_expander u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample)
    );

    // Bench copy of the step table, written independently of the RTL.
    function automatic int tb_step(input int i);
        int lo[44] = '{7, 8, 9, 10, 11, 12, 13, 14, 16, 17, 19, 21, 23, 25, 28, 31,
                       34, 37, 41, 45, 50, 55, 60, 66, 73, 80, 88, 97, 107, 118, 130, 143,
                       157, 173, 190, 209, 230, 253, 279, 307, 337, 371, 408, 449};
        int hi[45] = '{494, 544, 598, 658, 724, 796, 876, 963, 1060, 1166, 1282, 1411,
                       1552, 1707, 1878, 2066, 2272, 2499, 2749, 3024, 3327, 3660, 4026,
                       4428, 4871, 5358, 5894, 6484, 7132, 7845, 8630, 9493, 10442, 11487,
                       12635, 13899, 15289, 16818, 18500, 20350, 22385, 24623, 27086,
                       29794, 32767};
        if (i < 44) return lo[i];
        return hi[i - 44];
    endfunction

    // Reference model of one code update (R3..R7).
    function automatic int model_code(input logic [3:0] c);
        int adj[8] = '{-1, -1, -1, -1, 2, 4, 6, 8};
        int s = tb_step(ref_idx);
        int a = 0;
        int v;
        if (c[2]) a += s;
        if (c[1]) a += s / 2;
        if (c[0]) a += s / 4;
        v = c[3] ? ref_pred - a : ref_pred + a;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        ref_pred = v;
        ref_idx  = ref_idx + adj[c[2:0]];
        if (ref_idx < 0)  ref_idx = 0;
        if (ref_idx > 88) ref_idx = 88;
        return v;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ref_pred = 0; ref_idx = 0;
    endtask

    // Send one byte, collect both samples, check order, hold and ready.
    task automatic push_byte(input logic [7:0] b, input int hold,
                             output int s_hi, output int s_lo);
        int e_hi, e_lo;
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        e_hi = model_code(b[7:4]);
        e_lo = model_code(b[3:0]);
        s_hi = out_sample;
        check(out_sample, e_hi, "R2 R10 upper nibble sample");
        check(in_ready, 0, "R9 no byte taken while pending");
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(out_sample, e_hi, "R8 sample held under back-pressure");
        end
        out_ready = 1'b1;
        @(negedge clk);
        s_lo = out_sample;
        check(out_sample, e_lo, "R2 R10 lower nibble sample");
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(out_valid, 0, "R1 out_valid after reset");
        check(in_ready, 1, "R1 in_ready after reset");
    endtask

    task automatic t_floor_and_timing();
        int h, l;
        do_reset();
        push_byte(8'h04, 0, h, l);
        check(h, 0, "R1 R3 zero code keeps sample");
        check(l, 7, "R1 R6 R7 index floor then step 7");
        push_byte(8'h40, 0, h, l);
        check(h, 16, "R7 step read before update (idx 2 -> 9)");
    endtask

    task automatic t_magnitude();
        int h, l;
        do_reset();
        push_byte(8'h12, 1, h, l);
        check(h, 1, "R3 quarter step only");
        check(l, 4, "R3 half step only");
        push_byte(8'h73, 2, h, l);
        check(h, 15, "R3 all three terms");
        check(l, 27, "R3 R6 index +8 then step 16");
    endtask

    task automatic t_sign();
        int h, l;
        do_reset();
        push_byte(8'hC4, 0, h, l);
        check(h, -7, "R4 negative code subtracts");
        check(l, 2, "R4 positive code adds");
    endtask

    task automatic t_saturation();
        int h, l;
        do_reset();
        for (int k = 0; k < 12; k++) push_byte(8'h77, 0, h, l);
        check(l, 32767, "R5 positive saturation");
        for (int k = 0; k < 3; k++) push_byte(8'hFF, 0, h, l);
        check(l, -32768, "R5 negative saturation");
        push_byte(8'h08, 0, h, l);
        check(h, -32768, "R6 R10 zero magnitude at ceiling index");
    endtask

    task automatic t_back_to_back();
        int e;
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h45; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        e = model_code(4'h4);
        check(out_sample, e, "R2 first sample");
        out_ready = 1'b1;
        @(negedge clk);
        e = model_code(4'h5);
        check(out_sample, e, "R2 second sample");
        in_valid = 1'b1; in_byte = 8'hA6;
        #1;
        check(in_ready, 1, "R9 ready when last sample leaves");
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        e = model_code(4'hA);
        check(out_sample, e, "R9 R10 byte taken back-to-back");
        check(out_valid, 1, "R9 new sample valid");
        out_ready = 1'b1;
        @(negedge clk);
        e = model_code(4'h6);
        check(out_sample, e, "R10 lower nibble after back-to-back");
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid, 0, "R9 empty after both samples");
    endtask

    task automatic t_random_stream();
        int h, l;
        do_reset();
        for (int k = 0; k < 300; k++) push_byte(8'($urandom), k % 3, h, l);
    endtask

    initial begin
        t_reset();
        t_floor_and_timing();
        t_magnitude();
        t_sign();
        t_saturation();
        t_back_to_back();
        t_random_stream();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule